// File: doc/BRIEF.md
# Glyph and color pixel serializer

The serializer turns character and graphics bytes into one color per dot clock. A glyph byte, already looked up in an external font table, is held in a staging register. It moves into a shift register on the same edge that a new color byte is captured. From then on the shift register sends one bit per dot, most significant bit first. A 1 bit selects the foreground color and a 0 bit selects the background color. In the two-color modes the color byte acts as a tiny palette. Its two low bits choose the font that the external lookup must use for the following character.

There are four modes. Both text modes send eight dots per character and differ only in the font row they ask for. In dither graphics, one combined strobe loads the color byte together with a 4-dot pattern. The block generates that pattern itself from the font field and from the parity of the line. In direct-color graphics the color byte goes straight to the output as an 8-bit 3:3:2 value. A blank input forces the output to black.

Top module: `pix_serializer`

## Requirements
- R1: After reset, `pix_rgb`, `font_sel` and `font_row` are all zero.
- R2: The color byte is packed as foreground RGB in bits [7:5], background RGB in bits [4:2] and font field in bits [1:0]. A 3-bit RGB color is widened to 3:3:2 by repeating its red bit three times, its green bit three times and its blue bit twice.
- R3: In the text modes (`mode` 0 = high-resolution text, 1 = low-resolution text), `glyph_load` captures `glyph_in`. A later `color_load` moves that glyph into the shift register and captures `color_in` on the same edge. The glyph's bits then appear on `pix_rgb` one per cycle, MSB first. The first bit appears two edges after the `color_load` edge is sampled, counting that edge.
- R4: A 1 bit gives the foreground color and a 0 bit gives the background color. Once the loaded bits are used up, the background color is shown until the next load.
- R5: `font_sel` shows the font field of the most recently captured color byte, from the edge after `color_load`. This font field is meant for the following character.
- R6: `font_row` is registered from `line_idx`. In mode 0 it is `line_idx` modulo 8. In all other modes it is `line_idx` unchanged.
- R7: In mode 2 (dither graphics), `color_load` loads a 4-dot pattern, chosen by the font field of `color_in` and by `line_idx[0]` (1 = odd line). Then 4 pixels follow and after them the background color. The patterns, leftmost dot first and 1 meaning foreground, are as follows. Pattern 0 is 1100 on every line. Pattern 1 is 1010 on even lines and 0101 on odd lines. Pattern 2 is 1000 on even lines and 0010 on odd lines. Pattern 3 is 1110 on even lines and 1011 on odd lines. In mode 2, `glyph_in` has no effect on the pixels.
- R8: In mode 3 (direct color), `pix_rgb` equals the captured color byte, one edge after the color register is loaded.
- R9: When `blank` is high at an edge, `pix_rgb` is 0 after that edge, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 hi-res text, 1 lo-res text, 2 dither graphics, 3 direct color |
| line_idx | input | ROW_W | Current scan line within the repeated memory line |
| glyph_load | input | 1 | Capture `glyph_in` into the staging register |
| glyph_in | input | GLYPH_W | Glyph row from the external font lookup |
| color_load | input | 1 | Capture `color_in` and load the shift register |
| color_in | input | 8 | Color byte |
| blank | input | 1 | Force black output |
| pix_rgb | output | 8 | Registered 3:3:2 pixel color |
| font_sel | output | 2 | Font field for the following character |
| font_row | output | ROW_W | Registered glyph row index for the font lookup |

## Verification
Latency is fixed for each output. `font_sel` and `font_row` settle one edge after their inputs. In direct-color mode, a pixel appears two edges after its `color_load` is sampled. In text and dither modes, the first shifted pixel also appears two edges after `color_load`, and each following pixel one edge later. The bench drives inputs on falling edges and samples each output on the falling edge after the rising edge at which that output is due. Expected values come from the packing, widening and pattern rules stated in the requirements.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int COLOR_W  = 8;
  localparam int RGB3_W   = 3;
  localparam int FONT_W   = 2;
  localparam int DITHER_W = 4;

  typedef enum logic [1:0] {
    MODE_TXT_HI  = 2'd0,
    MODE_TXT_LO  = 2'd1,
    MODE_GFX_DTH = 2'd2,
    MODE_GFX_DIR = 2'd3
  } pix_mode_e;

  // widen one-bit-per-primary color to 3:3:2
  function automatic logic [COLOR_W-1:0] widen_rgb(input logic [RGB3_W-1:0] c);
    return {{3{c[2]}}, {3{c[1]}}, {2{c[0]}}};
  endfunction

  // fixed 4-dot patterns, leftmost dot in the MSB, 1 = foreground
  function automatic logic [DITHER_W-1:0] dither_bits(input logic [FONT_W-1:0] sel,
                                                      input logic odd);
    logic [DITHER_W-1:0] p;
    case (sel)
      2'd0:    p = 4'b1100;
      2'd1:    p = odd ? 4'b0101 : 4'b1010;
      2'd2:    p = odd ? 4'b0010 : 4'b1000;
      default: p = odd ? 4'b1011 : 4'b1110;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pxs_glyph_stage.sv
module pxs_glyph_stage
  import pxs_pkg::*;
#(
  parameter int GLYPH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               glyph_load,
  input  logic [GLYPH_W-1:0] glyph_in,
  input  logic               shift_load,
  input  logic [FONT_W-1:0]  pat_sel,
  input  logic               line_odd,
  output logic               dot_bit
);
  localparam int PAD_W = GLYPH_W - DITHER_W;

  logic [GLYPH_W-1:0] glyph_q;
  logic [GLYPH_W-1:0] shreg_q;
  logic [GLYPH_W-1:0] load_val;

  always_comb begin
    if (mode == MODE_GFX_DTH)
      load_val = {dither_bits(pat_sel, line_odd), {PAD_W{1'b0}}};
    else
      load_val = glyph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glyph_q <= '0;
      shreg_q <= '0;
    end else begin
      if (glyph_load)
        glyph_q <= glyph_in;
      if (shift_load)
        shreg_q <= load_val;
      else
        shreg_q <= {shreg_q[GLYPH_W-2:0], 1'b0};
    end
  end

  assign dot_bit = shreg_q[GLYPH_W-1];
endmodule

// File: rtl/pxs_color_stage.sv
module pxs_color_stage
  import pxs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               color_load,
  input  logic [COLOR_W-1:0] color_in,
  output logic [COLOR_W-1:0] color_q,
  output logic [FONT_W-1:0]  font_sel
);
  always_ff @(posedge clk) begin
    if (rst)
      color_q <= '0;
    else if (color_load)
      color_q <= color_in;
  end

  assign font_sel = color_q[FONT_W-1:0];
endmodule

// File: rtl/pxs_pixel_out.sv
module pxs_pixel_out
  import pxs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               blank,
  input  logic               dot_bit,
  input  logic [COLOR_W-1:0] color_q,
  output logic [COLOR_W-1:0] pix_rgb
);
  logic [RGB3_W-1:0]  fg, bg;
  logic [COLOR_W-1:0] pix_d;

  assign fg = color_q[COLOR_W-1 -: RGB3_W];
  assign bg = color_q[COLOR_W-RGB3_W-1 -: RGB3_W];

  always_comb begin
    if (blank)
      pix_d = '0;
    else if (mode == MODE_GFX_DIR)
      pix_d = color_q;
    else
      pix_d = widen_rgb(dot_bit ? fg : bg);
  end

  always_ff @(posedge clk) begin
    if (rst) pix_rgb <= '0;
    else     pix_rgb <= pix_d;
  end
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pxs_pkg::*;
#(
  parameter int GLYPH_W = 8,
  parameter int ROW_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic [ROW_W-1:0]   line_idx,
  input  logic               glyph_load,
  input  logic [GLYPH_W-1:0] glyph_in,
  input  logic               color_load,
  input  logic [7:0]         color_in,
  input  logic               blank,
  output logic [7:0]         pix_rgb,
  output logic [1:0]         font_sel,
  output logic [ROW_W-1:0]   font_row
);
  localparam logic [ROW_W-1:0] HI_ROW_MASK = ROW_W'((1 << (ROW_W-1)) - 1);

  logic               dot_bit;
  logic [COLOR_W-1:0] color_q;

  pxs_glyph_stage #(.GLYPH_W(GLYPH_W)) u_glyph (
    .clk(clk), .rst(rst), .mode(mode),
    .glyph_load(glyph_load), .glyph_in(glyph_in),
    .shift_load(color_load), .pat_sel(color_in[FONT_W-1:0]),
    .line_odd(line_idx[0]), .dot_bit(dot_bit)
  );

  pxs_color_stage u_color (
    .clk(clk), .rst(rst), .color_load(color_load), .color_in(color_in),
    .color_q(color_q), .font_sel(font_sel)
  );

  pxs_pixel_out u_pix (
    .clk(clk), .rst(rst), .mode(mode), .blank(blank),
    .dot_bit(dot_bit), .color_q(color_q), .pix_rgb(pix_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst)
      font_row <= '0;
    else if (mode == MODE_TXT_HI)
      font_row <= line_idx & HI_ROW_MASK;
    else
      font_row <= line_idx;
  end
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [ROW_W-1:0] line_idx,
  input logic             color_load,
  input logic [7:0]       color_in,
  input logic             blank,
  input logic [7:0]       pix_rgb,
  input logic [1:0]       font_sel,
  input logic [ROW_W-1:0] font_row
);
  assert_blank_black_R9: assert property (@(posedge clk) disable iff (rst)
    blank |=> pix_rgb == 8'h00);

  assert_font_next_R5: assert property (@(posedge clk) disable iff (rst)
    color_load |=> font_sel == $past(color_in[1:0]));

  assert_direct_color_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !blank && $past(color_load)) |=> pix_rgb == $past(color_in, 2));

  assert_two_color_R2: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd3 && !blank) |=> (pix_rgb[7:5] == 3'b000 || pix_rgb[7:5] == 3'b111));

  assert_hi_row_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> font_row[ROW_W-1] == 1'b0);

  assert_lo_row_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |=> font_row == $past(line_idx));
endmodule

bind pix_serializer pix_serializer_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .line_idx(line_idx),
  .color_load(color_load), .color_in(color_in), .blank(blank),
  .pix_rgb(pix_rgb), .font_sel(font_sel), .font_row(font_row)
);

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] line_idx = 4'd0;
  logic       glyph_load = 1'b0;
  logic [7:0] glyph_in = 8'h00;
  logic       color_load = 1'b0;
  logic [7:0] color_in = 8'h00;
  logic       blank = 1'b0;
  logic [7:0] pix_rgb;
  logic [1:0] font_sel;
  logic [3:0] font_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_serializer #(.GLYPH_W(8), .ROW_W(4)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .line_idx(line_idx),
    .glyph_load(glyph_load), .glyph_in(glyph_in),
    .color_load(color_load), .color_in(color_in), .blank(blank),
    .pix_rgb(pix_rgb), .font_sel(font_sel), .font_row(font_row)
  );

  function automatic logic [7:0] wide(input logic [2:0] c);
    return {c[2], c[2], c[2], c[1], c[1], c[1], c[0], c[0]};
  endfunction

  function automatic logic [3:0] pat(input logic [1:0] s, input logic odd);
    case (s)
      2'd0: return 4'b1100;
      2'd1: return odd ? 4'b0101 : 4'b1010;
      2'd2: return odd ? 4'b0010 : 4'b1000;
      default: return odd ? 4'b1011 : 4'b1110;
    endcase
  endfunction

  function automatic logic [7:0] dot(input logic b, input logic [7:0] c, input logic blk);
    if (blk) return 8'h00;
    return b ? wide(c[7:5]) : wide(c[4:2]);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_text(input logic [1:0] m, input logic [7:0] g, input logic [7:0] c,
                          input logic [3:0] ln, input logic blk);
    @(negedge clk);
    mode = m; line_idx = ln; blank = blk; glyph_load = 1'b1; glyph_in = g;
    @(negedge clk);
    glyph_load = 1'b0; color_load = 1'b1; color_in = c;
    @(negedge clk);
    color_load = 1'b0;
    chk("R5 font_sel", {6'd0, font_sel}, {6'd0, c[1:0]});
    chk("R6 font_row", {4'd0, font_row}, {4'd0, (m == 2'd0) ? (ln & 4'd7) : ln});
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(blk ? "R9 blank text" : "R3 R4 text dot", pix_rgb, dot(g[7-i], c, blk));
    end
    @(negedge clk);
    chk("R4 after glyph", pix_rgb, dot(1'b0, c, blk));
    blank = 1'b0;
  endtask

  task automatic run_dither(input logic [7:0] c, input logic [3:0] ln, input logic [7:0] g);
    logic [3:0] p;
    p = pat(c[1:0], ln[0]);
    @(negedge clk);
    mode = 2'd2; line_idx = ln; glyph_load = 1'b1; glyph_in = g;
    color_load = 1'b1; color_in = c;
    @(negedge clk);
    glyph_load = 1'b0; color_load = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 dither dot", pix_rgb, dot(p[3-i], c, 1'b0));
    end
    @(negedge clk);
    chk("R7 dither tail", pix_rgb, dot(1'b0, c, 1'b0));
  endtask

  task automatic run_direct(input logic [7:0] c, input logic blk);
    @(negedge clk);
    mode = 2'd3; color_load = 1'b1; color_in = c; blank = 1'b0;
    @(negedge clk);
    color_load = 1'b0; blank = blk;
    @(negedge clk);
    chk(blk ? "R9 blank direct" : "R8 direct", pix_rgb, blk ? 8'h00 : c);
    blank = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset pix", pix_rgb, 8'h00);
    chk("R1 reset font_sel", {6'd0, font_sel}, 8'h00);
    chk("R1 reset font_row", {4'd0, font_row}, 8'h00);
    rst = 1'b0;

    // directed text cases, R2 widening via fg=101 bg=010
    run_text(2'd0, 8'b1011_0010, {3'b101, 3'b010, 2'b11}, 4'd13, 1'b0);
    run_text(2'd1, 8'b0100_0001, {3'b111, 3'b000, 2'b01}, 4'd13, 1'b0);
    run_text(2'd0, 8'hFF, 8'hE6, 4'd2, 1'b1);
    // dither: every pattern on both parities; glyph_in must not matter
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 2; o++)
        run_dither({3'b110, 3'b001, 2'(s)}, 4'(o + 2), 8'hA5);
    run_direct(8'h9C, 1'b0);
    run_direct(8'hFF, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      case (m)
        2'd2:    run_dither(8'($urandom), 4'($urandom), 8'($urandom));
        2'd3:    run_direct(8'($urandom), ($urandom % 4) == 0);
        default: run_text(m, 8'($urandom), 8'($urandom), 4'($urandom), ($urandom % 5) == 0);
      endcase
    end

    done = 1'b1;
    finish_run();
  end
endmodule